// File: doc/BRIEF.md
# SPI Byte Slave with Status Handshake

This block is a serial slave that moves one byte per framed transaction between an external SPI master and two byte queues on chip. The receive queue holds bytes written by the master, and the host logic drains it. The transmit queue is filled by the host logic and supplies bytes to the master on reads. Every frame is 12 SCLK cycles long. A three-bit header comes first, then eight data bits, then one status bit that the slave drives on MISO.

The status bit is the only flow control the master gets. On a write, status 0 means the byte was stored and status 1 means the receive queue was full, so the master sends the same byte again. On a read, status 0 means the byte is new and has been taken from the transmit queue. Status 1 means the queue was empty and the byte is a repeat of the last byte delivered, so the master reads again later.

All SPI inputs are sampled in the system clock domain through synchronisers. SCLK edges are found there as well. SCLK must therefore run well below the system clock.

Top module: `spis_handshake`

## Requirements
- R1: After reset, MISO is 0, the receive queue reports no data (`rx_valid_o` = 0) and the transmit queue is not full.
- R2: While idle, a frame starts only at a rising SCLK edge where select and MOSI are both high. Rising edges with MOSI low do not start a frame.
- R3: A frame is 12 rising SCLK edges: start bit 1, direction bit (1 = read, 0 = write), a select bit, eight data bits MSB first, and one status cycle. During a read, data bit n appears on MISO after the rising edge of cycle 3+(7-n).
- R4: A write whose status cycle is reached while the receive queue has room drives status 0 and appends the byte to the receive queue.
- R5: A write that reaches its status cycle while the receive queue is full drives status 1 and stores nothing.
- R6: A read while the transmit queue holds data returns the head byte MSB first, drives status 0 and removes that byte.
- R7: A read while the transmit queue is empty returns the byte last delivered with status 0 (0x00 after reset), drives status 1 and removes nothing.
- R8: If select goes low before the status cycle, the frame is dropped. Nothing is pushed or popped, and the next frame is decoded normally.
- R9: The status bit is driven from the rising edge of cycle 11. MISO returns to 0 at the next rising SCLK edge.
- R10: The value of the select bit (cycle 2) has no effect on the transfer.
- R11: Both queues are first in, first out. `tx_full_o` is 1 when the transmit queue holds its depth of bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the master |
| cs_i | input | 1 | Slave select, active high |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data and status to the master |
| rx_data_o | output | DATA_W | Head byte of the receive queue |
| rx_valid_o | output | 1 | Receive queue holds data |
| rx_pop_i | input | 1 | Remove the head byte of the receive queue |
| tx_data_i | input | DATA_W | Byte to append to the transmit queue |
| tx_push_i | input | 1 | Append `tx_data_i` to the transmit queue |
| tx_full_o | output | 1 | Transmit queue is full |

## Verification
Writes are applied in three cases: an empty receive queue, a queue filling up to its depth, and a full queue. The full case separates accept from reject and shows that a refused byte never reaches the queue. Reads are applied to a queue holding two bytes and then to the drained queue. This separates fresh data, where the queue advances, from repeated data, where the last byte returns with status 1. Further frames cover select dropping partway through both a read and a write, idle SCLK edges with MOSI low before a start, and a select bit of 1. These show that framing never slips and that an aborted frame leaves both queues untouched.

// File: rtl/spis_pkg.sv
package spis_pkg;
  localparam int unsigned HDR_LEN = 3;  // start, direction, select
  localparam int unsigned DIR_IDX = 1;
  localparam int unsigned SEL_IDX = 2;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FRAME = 1'b1
  } spis_state_e;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spis_fifo.sv
module spis_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_wr, do_rd;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign do_wr   = push_i && !full_o;
  assign do_rd   = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_wr) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (do_rd) rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spis_frame.sv
module spis_frame
  import spis_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_i,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic              rx_full_i,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              tx_empty_i,
  input  logic [DATA_W-1:0] tx_head_i,
  output logic              tx_pop_o
);
  localparam int unsigned FRAME_LEN = HDR_LEN + DATA_W + 1;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] DIR_CNT  = CNT_W'(DIR_IDX);
  localparam logic [CNT_W-1:0] SEL_CNT  = CNT_W'(SEL_IDX);
  localparam logic [CNT_W-1:0] STAT_CNT = CNT_W'(FRAME_LEN - 1);

  spis_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sclk_q, rise;
  logic              rd_q, fresh_q, miso_q, push_q, pop_q;
  logic [DATA_W-1:0] shin_q, shout_q, byte_q, last_q;

  assign rise      = sclk_i && !sclk_q;
  assign miso_o    = miso_q;
  assign rx_push_o = push_q;
  assign tx_pop_o  = pop_q;
  assign rx_data_o = shin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sclk_q  <= 1'b0;
      rd_q    <= 1'b0;
      fresh_q <= 1'b0;
      miso_q  <= 1'b0;
      push_q  <= 1'b0;
      pop_q   <= 1'b0;
      shin_q  <= '0;
      shout_q <= '0;
      byte_q  <= '0;
      last_q  <= '0;
    end else begin
      sclk_q <= sclk_i;
      push_q <= 1'b0;
      pop_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (rise) begin
            miso_q <= 1'b0;  // status window closes here
            if (cs_i && mosi_i) begin
              state_q <= ST_FRAME;
              cnt_q   <= CNT_W'(1);
            end
          end
        end
        ST_FRAME: begin
          if (!cs_i) begin  // abort: no queue side effect
            state_q <= ST_IDLE;
            miso_q  <= 1'b0;
          end else if (rise) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == DIR_CNT) begin
              rd_q <= mosi_i;
            end else if (cnt_q == SEL_CNT) begin
              // select bit sampled but unused; pick read byte now
              fresh_q <= !tx_empty_i;
              byte_q  <= tx_empty_i ? last_q : tx_head_i;
              shout_q <= tx_empty_i ? last_q : tx_head_i;
            end else if (cnt_q == STAT_CNT) begin
              state_q <= ST_IDLE;
              if (rd_q) begin
                miso_q <= !fresh_q;
                if (fresh_q) begin
                  pop_q  <= 1'b1;
                  last_q <= byte_q;
                end
              end else begin
                miso_q <= rx_full_i;
                push_q <= !rx_full_i;
              end
            end else begin
              shin_q  <= {shin_q[DATA_W-2:0], mosi_i};
              miso_q  <= rd_q && shout_q[DATA_W-1];
              shout_q <= {shout_q[DATA_W-2:0], 1'b0};
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spis_handshake.sv
module spis_handshake #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned RX_DEPTH    = 4,
  parameter int unsigned TX_DEPTH    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_pop_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_push_i,
  output logic              tx_full_o
);
  logic              sclk_s, cs_s, mosi_s;
  logic              rx_push, rx_full, rx_empty;
  logic [DATA_W-1:0] rx_wdata;
  logic              tx_pop, tx_empty;
  logic [DATA_W-1:0] tx_head;

  spis_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, cs_i, mosi_i}),
    .q_o    ({sclk_s, cs_s, mosi_s})
  );

  spis_frame #(.DATA_W(DATA_W)) i_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (sclk_s),
    .cs_i       (cs_s),
    .mosi_i     (mosi_s),
    .miso_o     (miso_o),
    .rx_full_i  (rx_full),
    .rx_push_o  (rx_push),
    .rx_data_o  (rx_wdata),
    .tx_empty_i (tx_empty),
    .tx_head_i  (tx_head),
    .tx_pop_o   (tx_pop)
  );

  spis_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) i_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .data_i  (rx_wdata),
    .pop_i   (rx_pop_i),
    .head_o  (rx_data_o),
    .empty_o (rx_empty),
    .full_o  (rx_full)
  );

  spis_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) i_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_push_i),
    .data_i  (tx_data_i),
    .pop_i   (tx_pop),
    .head_o  (tx_head),
    .empty_o (tx_empty),
    .full_o  (tx_full_o)
  );

  assign rx_valid_o = !rx_empty;
endmodule

// File: rtl/spis_handshake_chk.sv
module spis_handshake_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_push_i,
  input logic rx_full_i,
  input logic tx_pop_i,
  input logic tx_empty_i,
  input logic rx_pop_i,
  input logic rx_valid_i,
  input logic tx_full_i,
  input logic tx_push_i
);
  a_r5_no_push_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i |-> !rx_full_i);

  a_r7_no_pop_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_i |-> !tx_empty_i);

  a_r3_one_op_per_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_push_i && tx_pop_i));

  a_r8_rx_only_moves_on_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_push_i && !rx_pop_i) |=> $stable(rx_valid_i));

  a_r11_tx_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full_i && !tx_pop_i) |=> tx_full_i);

  a_r11_tx_fills_by_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_full_i) |-> $past(tx_push_i));
endmodule

bind spis_handshake spis_handshake_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_push_i  (rx_push),
  .rx_full_i  (rx_full),
  .tx_pop_i   (tx_pop),
  .tx_empty_i (tx_empty),
  .rx_pop_i   (rx_pop_i),
  .rx_valid_i (rx_valid_o),
  .tx_full_i  (tx_full_o),
  .tx_push_i  (tx_push_i)
);

// File: tb/test_spis_handshake.sv
module test_spis_handshake;
  localparam int HALF = 10;  // sys clocks per SCLK phase

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, cs = 1'b0, mosi = 1'b0;
  logic       miso;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_pop = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_push = 1'b0;
  logic       tx_full;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  spis_handshake i_spis_handshake (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_i(cs), .mosi_i(mosi),
    .miso_o(miso), .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_pop_i(rx_pop),
    .tx_data_i(tx_data), .tx_push_i(tx_push), .tx_full_o(tx_full)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b, output logic o);
    mosi = b;
    wait_clk(HALF);
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
    wait_clk(HALF);
    o = miso;
  endtask

  // full frame: start, dir, sel, 8 data, status
  task automatic xfer(input logic rd, input logic sel, input logic [7:0] d,
                      output logic [7:0] rdata, output logic st);
    logic o;
    cs = 1'b1;
    wait_clk(4);
    sbit(1'b1, o);
    sbit(rd, o);
    sbit(sel, o);
    for (int i = 7; i >= 0; i--) begin
      sbit(rd ? 1'b0 : d[i], o);
      rdata[i] = o;
    end
    sbit(1'b0, st);
    cs = 1'b0;
    wait_clk(6);
  endtask

  task automatic push_tx(input logic [7:0] d);
    tx_data = d;
    tx_push = 1'b1;
    wait_clk(1);
    tx_push = 1'b0;
    wait_clk(1);
  endtask

  task automatic pop_rx(input string req, input logic [7:0] exp);
    check(req, {7'd0, rx_valid}, 8'd1);
    check(req, rx_data, exp);
    rx_pop = 1'b1;
    wait_clk(1);
    rx_pop = 1'b0;
    wait_clk(1);
  endtask

  task automatic t_reset();
    check("R1 miso", {7'd0, miso}, 8'd0);
    check("R1 rx_valid", {7'd0, rx_valid}, 8'd0);
    check("R1 tx_full", {7'd0, tx_full}, 8'd0);
  endtask

  task automatic t_read_empty_after_reset();
    logic [7:0] d; logic st; logic o;
    xfer(1'b1, 1'b0, 8'h00, d, st);
    check("R7 data", d, 8'h00);
    check("R7 status", {7'd0, st}, 8'd1);
    // status then one idle edge: MISO back to 0
    cs = 1'b1; wait_clk(4);
    sbit(1'b1, o); sbit(1'b1, o); sbit(1'b0, o);
    for (int i = 0; i < 8; i++) sbit(1'b0, o);
    sbit(1'b0, o);
    check("R9 status", {7'd0, o}, 8'd1);
    sbit(1'b0, o);
    check("R9 miso clears", {7'd0, o}, 8'd0);
    cs = 1'b0; wait_clk(6);
  endtask

  task automatic t_write_accept();
    logic [7:0] d; logic st;
    xfer(1'b0, 1'b0, 8'hA5, d, st);
    check("R4 status", {7'd0, st}, 8'd0);
    xfer(1'b0, 1'b1, 8'h3C, d, st);
    check("R10 status", {7'd0, st}, 8'd0);
    pop_rx("R4 data", 8'hA5);
    pop_rx("R10 data", 8'h3C);
    check("R11 rx drained", {7'd0, rx_valid}, 8'd0);
  endtask

  task automatic t_write_full();
    logic [7:0] d; logic st;
    for (int i = 0; i < 4; i++) begin
      xfer(1'b0, 1'b0, 8'h10 + 8'(i), d, st);
      check("R4 fill status", {7'd0, st}, 8'd0);
    end
    xfer(1'b0, 1'b0, 8'hFF, d, st);
    check("R5 reject status", {7'd0, st}, 8'd1);
    for (int i = 0; i < 4; i++) pop_rx("R11 rx order", 8'h10 + 8'(i));
    check("R5 nothing stored", {7'd0, rx_valid}, 8'd0);
    xfer(1'b0, 1'b0, 8'hFF, d, st);
    check("R5 retry accepted", {7'd0, st}, 8'd0);
    pop_rx("R5 retry data", 8'hFF);
  endtask

  task automatic t_read_fresh();
    logic [7:0] d; logic st;
    push_tx(8'h81);
    push_tx(8'h5A);
    xfer(1'b1, 1'b0, 8'h00, d, st);
    check("R6 data1", d, 8'h81);
    check("R6 status1", {7'd0, st}, 8'd0);
    xfer(1'b1, 1'b1, 8'h00, d, st);
    check("R6 data2", d, 8'h5A);
    check("R6 status2", {7'd0, st}, 8'd0);
    xfer(1'b1, 1'b0, 8'h00, d, st);
    check("R7 stale data", d, 8'h5A);
    check("R7 stale status", {7'd0, st}, 8'd1);
  endtask

  task automatic t_tx_full();
    logic [7:0] d; logic st;
    for (int i = 0; i < 4; i++) push_tx(8'hC0 + 8'(i));
    check("R11 tx_full", {7'd0, tx_full}, 8'd1);
    for (int i = 0; i < 4; i++) begin
      xfer(1'b1, 1'b0, 8'h00, d, st);
      check("R11 tx order", d, 8'hC0 + 8'(i));
      check("R6 drain status", {7'd0, st}, 8'd0);
    end
    check("R11 tx not full", {7'd0, tx_full}, 8'd0);
  endtask

  task automatic t_abort();
    logic [7:0] d; logic st; logic o;
    push_tx(8'h77);
    cs = 1'b1; wait_clk(4);
    sbit(1'b1, o); sbit(1'b1, o); sbit(1'b0, o);
    for (int i = 0; i < 5; i++) sbit(1'b0, o);
    cs = 1'b0; wait_clk(8);
    check("R8 miso after abort", {7'd0, miso}, 8'd0);
    cs = 1'b1; wait_clk(4);
    sbit(1'b1, o); sbit(1'b0, o); sbit(1'b0, o);
    for (int i = 0; i < 8; i++) sbit(1'b1, o);
    cs = 1'b0; wait_clk(8);
    check("R8 no push", {7'd0, rx_valid}, 8'd0);
    xfer(1'b1, 1'b0, 8'h00, d, st);
    check("R8 no pop data", d, 8'h77);
    check("R8 no pop status", {7'd0, st}, 8'd0);
  endtask

  task automatic t_idle_edges();
    logic [7:0] d; logic st; logic o;
    cs = 1'b1; wait_clk(4);
    for (int i = 0; i < 3; i++) sbit(1'b0, o);
    xfer(1'b0, 1'b0, 8'h96, d, st);
    check("R2 status", {7'd0, st}, 8'd0);
    pop_rx("R2 data", 8'h96);
  endtask

  initial begin
    wait_clk(5);
    t_reset();
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_read_empty_after_reset();
    t_write_accept();
    t_write_full();
    t_read_fresh();
    t_tx_full();
    t_abort();
    t_idle_edges();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule